// File: doc/BRIEF.md
# Bus Turnaround Idle Inserter

This block sits between the access sequencer of an external bus controller and the bus itself. Some memories keep driving the shared data bus for a while after their read strobe is removed. If the next access goes to another device, or turns the bus around for a write, the two drivers can overlap. The inserter remembers the area number and direction of the last granted access. When a new request would create such a hazard, it holds the grant low for a programmed number of idle cycles.

The idle counts live in a 16-bit configuration register that software reads and writes directly. The register holds one 2-bit count per memory area. Only the power-on reset initialises this register. A manual reset clears the access history and any idle countdown in progress, but leaves the programmed counts in place.

A request is presented with `reqValid`, `reqArea` and `reqWrite`. It must stay stable until `grant` is seen high at a rising clock edge, and that edge is the cycle in which the access is taken. `grant` is combinational from the request and the internal state.

Top module: `turnaround_idle_inserter`

## Requirements
- R1: After power-on reset the configuration register reads 16'h3FF3.
- R2: A register write stores bits [13:4] and [1:0]. Bits 15, 14, 3 and 2 always read 0, and writing them has no effect.
- R3: The count for area a is bits [2a+1:2a]. Areas 1 and 7 have no writable count and always give zero idle cycles.
- R4: If a request targets a different area than the last granted access, grant stays low for exactly N cycles and is high in cycle N, where N is the count of the previous access's area and the request's first cycle is cycle 0.
- R5: A write to the same area as a preceding read is held for N cycles, with N the count of that area.
- R6: A read after a read, a write after a write, or a read after a write to the same area is granted in the request's first cycle.
- R7: A count of 0 inserts no idle cycles, even on an area change or a read-to-write turnaround.
- R8: The first request after power-on reset is granted at once.
- R9: A manual reset (manRstN low) leaves the register unchanged and clears the history, so the next request is granted at once.
- R10: grant is high only while reqValid is high, and it is always low while manRstN is low.
- R11: When a register write falls in the first cycle of a request that needs idle cycles, that request uses the old count. The new value applies to later decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| manRstN | input | 1 | Manual reset, synchronous, active low, clears history only |
| reqValid | input | 1 | Access request pending |
| reqArea | input | 3 | Memory area of the request |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| grant | output | 1 | Request may proceed this cycle |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 16 | Configuration register write data |
| regRdData | output | 16 | Configuration register contents |

## Verification
A register write and a turnaround decision can fall in the same cycle. That cycle is the first cycle of a stalled request, in which the count is loaded from the old field value. The bench provokes this by raising a request to a new area and writing the previous area's count in the same clock. It then checks two things: the stall length matches the old count, and the following turnaround uses the new count. A request raised while manual reset is asserted is a second overlap. There, grant must stay low and the register must keep its value.

// File: rtl/tii_pkg.sv
`timescale 1ns/1ps
package tii_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic loadCnt;      // start an idle countdown
    logic decCnt;       // count one idle cycle
    logic recordAccess; // remember the granted access
    logic clearHistory; // forget history (manual reset)
  } ctlStrobes_t;
endpackage

// File: rtl/tii_datapath.sv
`timescale 1ns/1ps
module tii_datapath
  import tii_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int FIELD_W   = 2,
  parameter logic [NUM_AREAS*FIELD_W-1:0] RST_VAL = 'h3FF3,
  parameter logic [NUM_AREAS*FIELD_W-1:0] WR_MASK = 'h3FF3
) (
  input  logic                           clk,
  input  logic                           porRstN,
  input  logic                           regWrEn,
  input  logic [NUM_AREAS*FIELD_W-1:0]   regWrData,
  input  logic [$clog2(NUM_AREAS)-1:0]   reqArea,
  input  logic                           reqWrite,
  input  ctlStrobes_t                    strobes,
  output logic [NUM_AREAS*FIELD_W-1:0]   cfgOut,
  output logic                           prevValid,
  output logic [$clog2(NUM_AREAS)-1:0]   prevArea,
  output logic                           prevWrite,
  output logic [FIELD_W-1:0]             prevField,
  output logic                           cntZero,
  output logic                           waited
);
  localparam int AREA_W = $clog2(NUM_AREAS);
  localparam int REG_W  = NUM_AREAS * FIELD_W;

  logic [REG_W-1:0]   cfgReg;
  logic [FIELD_W-1:0] idleCnt;
  logic [FIELD_W-1:0] fieldArr [NUM_AREAS];

  // configuration register: only power-on reset touches it
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)     cfgReg <= RST_VAL & WR_MASK;
    else if (regWrEn) cfgReg <= regWrData & WR_MASK;
  end

  // one count field per area
  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_field
    assign fieldArr[a] = cfgReg[a*FIELD_W +: FIELD_W];
  end

  // access history and idle countdown
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      prevValid <= 1'b0;
      prevArea  <= '0;
      prevWrite <= 1'b0;
      idleCnt   <= '0;
      waited    <= 1'b0;
    end else if (strobes.clearHistory) begin
      prevValid <= 1'b0;
      prevArea  <= '0;
      prevWrite <= 1'b0;
      idleCnt   <= '0;
      waited    <= 1'b0;
    end else begin
      if (strobes.recordAccess) begin
        prevValid <= 1'b1;
        prevArea  <= reqArea;
        prevWrite <= reqWrite;
        waited    <= 1'b0;
      end
      if (strobes.loadCnt) begin
        idleCnt <= prevField - FIELD_W'(1);
        waited  <= 1'b1;
      end else if (strobes.decCnt) begin
        idleCnt <= idleCnt - FIELD_W'(1);
      end
    end
  end

  assign prevField = fieldArr[prevArea];
  assign cntZero   = (idleCnt == '0);
  assign cfgOut    = cfgReg;

  logic unusedBits;
  assign unusedBits = ^AREA_W;
endmodule

// File: rtl/tii_control.sv
`timescale 1ns/1ps
module tii_control
  import tii_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int FIELD_W   = 2
) (
  input  logic                         manRstN,
  input  logic                         reqValid,
  input  logic [$clog2(NUM_AREAS)-1:0] reqArea,
  input  logic                         reqWrite,
  input  logic                         prevValid,
  input  logic [$clog2(NUM_AREAS)-1:0] prevArea,
  input  logic                         prevWrite,
  input  logic [FIELD_W-1:0]           prevField,
  input  logic                         cntZero,
  input  logic                         waited,
  output logic                         grant,
  output ctlStrobes_t                  strobes
);
  logic areaChange;
  logic readToWrite;
  logic needIdle;

  always_comb begin
    areaChange  = (reqArea != prevArea);
    readToWrite = !prevWrite && reqWrite;
    needIdle    = prevValid && !waited && (areaChange || readToWrite)
                  && (prevField != '0);
    grant       = manRstN && reqValid && cntZero && !needIdle;

    strobes.loadCnt      = manRstN && reqValid && cntZero && needIdle;
    strobes.decCnt       = !cntZero;
    strobes.recordAccess = grant;
    strobes.clearHistory = !manRstN;
  end
endmodule

// File: rtl/turnaround_idle_inserter.sv
`timescale 1ns/1ps
module turnaround_idle_inserter
  import tii_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int FIELD_W   = 2,
  parameter logic [NUM_AREAS*FIELD_W-1:0] RST_VAL = 'h3FF3,
  parameter logic [NUM_AREAS*FIELD_W-1:0] WR_MASK = 'h3FF3
) (
  input  logic                           clk,
  input  logic                           porRstN,
  input  logic                           manRstN,
  input  logic                           reqValid,
  input  logic [$clog2(NUM_AREAS)-1:0]   reqArea,
  input  logic                           reqWrite,
  output logic                           grant,
  input  logic                           regWrEn,
  input  logic [NUM_AREAS*FIELD_W-1:0]   regWrData,
  output logic [NUM_AREAS*FIELD_W-1:0]   regRdData
);
  localparam int AREA_W = $clog2(NUM_AREAS);

  ctlStrobes_t        strobes;
  logic               prevValid;
  logic [AREA_W-1:0]  prevArea;
  logic               prevWrite;
  logic [FIELD_W-1:0] prevField;
  logic               cntZero;
  logic               waited;

  tii_datapath #(
    .NUM_AREAS(NUM_AREAS), .FIELD_W(FIELD_W),
    .RST_VAL(RST_VAL), .WR_MASK(WR_MASK)
  ) dpath_i (
    .clk(clk), .porRstN(porRstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .reqArea(reqArea), .reqWrite(reqWrite), .strobes(strobes),
    .cfgOut(regRdData), .prevValid(prevValid), .prevArea(prevArea),
    .prevWrite(prevWrite), .prevField(prevField), .cntZero(cntZero),
    .waited(waited)
  );

  tii_control #(.NUM_AREAS(NUM_AREAS), .FIELD_W(FIELD_W)) ctrl_i (
    .manRstN(manRstN), .reqValid(reqValid), .reqArea(reqArea),
    .reqWrite(reqWrite), .prevValid(prevValid), .prevArea(prevArea),
    .prevWrite(prevWrite), .prevField(prevField), .cntZero(cntZero),
    .waited(waited), .grant(grant), .strobes(strobes)
  );
endmodule

// File: rtl/tii_checker.sv
`timescale 1ns/1ps
module tii_checker #(
  parameter int NUM_AREAS = 8,
  parameter int FIELD_W   = 2,
  parameter logic [NUM_AREAS*FIELD_W-1:0] WR_MASK = 'h3FF3
) (
  input logic                         clk,
  input logic                         porRstN,
  input logic                         manRstN,
  input logic                         reqValid,
  input logic [$clog2(NUM_AREAS)-1:0] reqArea,
  input logic                         reqWrite,
  input logic                         grant,
  input logic                         regWrEn,
  input logic [NUM_AREAS*FIELD_W-1:0] regRdData,
  input logic                         cntZero
);
  // R10: grant only with a request and outside manual reset
  a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!porRstN)
    grant |-> (reqValid && manRstN));

  // R2: reserved bits never read as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!porRstN)
    (regRdData & ~WR_MASK) == '0);

  // R9: manual reset leaves the register alone
  a_r9_reg_kept: assert property (@(posedge clk) disable iff (!porRstN)
    (!manRstN && !regWrEn) |=> (regRdData == $past(regRdData)));

  // R4: no grant while an idle countdown is running
  a_r4_no_grant_counting: assert property (@(posedge clk) disable iff (!porRstN)
    !cntZero |-> !grant);

  // R6: same area without a read-to-write turn is granted at once
  a_r6_same_area_free: assert property (@(posedge clk)
    disable iff (!porRstN || !manRstN)
    grant |=> (!(reqValid && reqArea == $past(reqArea)
                 && (!reqWrite || $past(reqWrite))) || grant));
endmodule

bind turnaround_idle_inserter tii_checker #(
  .NUM_AREAS(NUM_AREAS), .FIELD_W(FIELD_W), .WR_MASK(WR_MASK)
) chk_i (
  .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .reqValid(reqValid),
  .reqArea(reqArea), .reqWrite(reqWrite), .grant(grant), .regWrEn(regWrEn),
  .regRdData(regRdData), .cntZero(cntZero)
);

// File: tb/turnaround_idle_inserter_tb.sv
`timescale 1ns/1ps
module turnaround_idle_inserter_tb_top;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        manRstN = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqArea = '0;
  logic        reqWrite = 1'b0;
  logic        grant;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  turnaround_idle_inserter dut_i (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .reqValid(reqValid),
    .reqArea(reqArea), .reqWrite(reqWrite), .grant(grant), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // present one request, count stalled cycles up to grant
  task automatic access(int area, bit wr, int expStall, string tag);
    int stalls = 0;
    @(negedge clk);
    reqValid = 1'b1; reqArea = area[2:0]; reqWrite = wr;
    #1;
    while (!grant && stalls < 8) begin
      stalls++;
      @(negedge clk); #1;
    end
    checkEq(tag, stalls, expStall);
  endtask

  task automatic regWrite(logic [15:0] v);
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkReg(logic [15:0] exp, string tag);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    checkEq(tag, int'(regRdData), int'(exp));
  endtask

  task automatic testResetState();
    checkReg(16'h3FF3, "R1 power-on value");
    access(0, 0, 0, "R8 first access undelayed");
  endtask

  task automatic testSameArea();
    access(0, 0, 0, "R6 read after read");
    access(0, 1, 3, "R5 read to write same area");
    access(0, 1, 0, "R6 write after write");
    access(0, 0, 0, "R6 read after write");
  endtask

  task automatic testAreaChange();
    access(2, 0, 3, "R4 area 0 to 2");
    access(5, 1, 3, "R4 area 2 to 5");
  endtask

  task automatic testRegister();
    regWrite(16'hFFFF);
    checkReg(16'h3FF3, "R2 all ones masked");
    regWrite(16'h0000);
    checkReg(16'h0000, "R2 all zeros");
    regWrite(16'hEC2D);
    checkReg(16'h2C21, "R2 reserved bits ignored");
  endtask

  task automatic testCounts();
    access(2, 0, 3, "R4 count 3 from area 5");
    access(0, 0, 2, "R4 count 2 from area 2");
    access(4, 0, 1, "R4 count 1 from area 0");
    access(6, 0, 0, "R7 count 0 from area 4");
    access(1, 0, 2, "R3 area 6 field bits 13:12");
    access(6, 1, 0, "R3 area 1 has no count");
    access(7, 0, 2, "R4 count 2 from area 6");
    access(3, 1, 0, "R3 area 7 has no count");
    access(3, 0, 0, "R6 same area read");
    access(3, 1, 0, "R7 read to write count 0");
  endtask

  task automatic testWriteCollision();
    int stalls = 0;
    regWrite(16'h2CE1);                      // area 3 count = 3
    checkReg(16'h2CE1, "R2 area 3 count written");
    @(negedge clk);
    reqValid = 1'b1; reqArea = 3'd0; reqWrite = 1'b0;
    regWrEn = 1'b1; regWrData = 16'h2C61;    // area 3 count -> 1, same cycle
    #1;
    while (!grant && stalls < 8) begin
      stalls++;
      @(negedge clk);
      regWrEn = 1'b0;
      #1;
    end
    regWrEn = 1'b0;
    checkEq("R11 old count used in write cycle", stalls, 3);
    access(3, 0, 1, "R4 count 1 from area 0");
    access(5, 0, 1, "R11 new count applies later");
  endtask

  task automatic testManualReset();
    @(negedge clk);
    reqValid = 1'b1; reqArea = 3'd6; reqWrite = 1'b1; manRstN = 1'b0;
    #1;
    checkEq("R10 no grant in manual reset", int'(grant), 0);
    @(negedge clk);
    manRstN = 1'b1; reqValid = 1'b0;
    #1;
    checkEq("R10 no grant without request", int'(grant), 0);
    checkReg(16'h2C61, "R9 register kept");
    access(2, 0, 0, "R9 history cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    testResetState();
    testSameArea();
    testAreaChange();
    testRegister();
    testCounts();
    testWriteCollision();
    testManualReset();
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule